// File: doc/BRIEF.md
# Stochastic Super-Pixel Counter Bank

This block takes the output bit-streams of a 4x4 group of per-pixel stochastic circuits. It turns them into binary counts at two resolutions at once. Each of the sixteen streams drives its own result counter, which gives the full-resolution image. A sixteen-way multiplexer picks one stream every cycle and feeds a seventeenth counter, which gives one low-resolution super-pixel equal to the average of the group. The multiplexer select comes from a 4-bit shift-register sequence that visits every input exactly once in each sixteen-cycle period. Over whole periods, the super-pixel count is therefore exactly the mean of the sixteen pixel counts.

A one-cycle start pulse clears all seventeen counters and launches a run whose length, in stream bits, is taken from the length input in that cycle. The counters can be read on any cycle of a run. Early readings are low-precision estimates of the final image, and a full 8-bit result needs 256 stream bits. When the programmed number of bits has been counted, the block raises a done flag and freezes every count until the next start.

Top module: `sc_superpixel_bank`

## Requirements
- R1: After reset, all seventeen counts are 0, `busy_o` and `done_o` are 0, and `sel_o` equals 1.
- R2: A cycle with `start_i` high clears all seventeen counts at the next clock edge, whatever state the block was in, and captures `len_i` as the run length.
- R3: In every cycle with `busy_o` high, the count of pixel i (field i of `pix_cnt_o`, bits i*9 to i*9+8) increases by `pix_i[i]`.
- R4: In every cycle with `busy_o` high, the super-pixel count increases by `pix_i[sel_o]`.
- R5: The first busy cycle of a run presents `sel_o` = 1. Every aligned group of sixteen busy cycles from the start of a run presents each of the values 0 to 15 exactly once.
- R6: A run with length L > 0 keeps `busy_o` high for exactly L cycles. At the edge that ends the last of them, `busy_o` falls and `done_o` rises, and `done_o` stays high until the next start.
- R7: A start with `len_i` = 0 gives `done_o` = 1 and `busy_o` = 0 after one edge, with all counts 0.
- R8: Asserting `start_i` during a run abandons that run and begins a fresh one from zero counts and select 1.
- R9: While `busy_o` is low and `start_i` is low, changes on `pix_i` have no effect on any count or on `sel_o`.
- R10: For a run of a multiple of sixteen cycles, sixteen times the super-pixel count equals the sum of the pixel counts when the pixel streams are constant. For random streams, it lies within a statistical tolerance of that sum.
- R11: A 256-cycle run of all-one streams ends with every count at exactly 256, with no wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | One-cycle pulse: clear counts and begin a run |
| len_i | input | 9 | Run length in stream bits, sampled with start_i |
| pix_i | input | 16 | Current bit of each pixel stream, bit i is pixel i |
| pix_cnt_o | output | 144 | Sixteen 9-bit pixel counts, pixel i in bits i*9+8 to i*9 |
| sp_cnt_o | output | 9 | Super-pixel count |
| sel_o | output | 4 | Multiplexer select applied in the current cycle |
| busy_o | output | 1 | A run is counting |
| done_o | output | 1 | The last run completed |

## Verification
The hardest case to reach is a start that arrives while a run is partway through. Here the clear must win over the increment in the same edge, and the select sequence must restart from its seed. The bench brings this about by launching a long run and pulsing start again after ten cycles, with a different pixel pattern. It then checks the second run's counts and the uniform select coverage. The zero-length start and the wrap-free count of 256 are each driven directly.

// File: rtl/sc_sp_pkg.sv
// Package: shared constants and the feedback-tap table for the select generator.
// Assumes select widths between 2 and 8 bits.
package sc_sp_pkg;
    localparam int unsigned DEF_NPIX  = 16;
    localparam int unsigned DEF_CNT_W = 9;

    // Return the feedback mask of a maximal-length shift register of width w
    function automatic logic [7:0] lfsr_taps(input int unsigned w);
        case (w)
            2:       return 8'b0000_0011;
            3:       return 8'b0000_0110;
            4:       return 8'b0000_1100;
            5:       return 8'b0001_0100;
            6:       return 8'b0011_0000;
            7:       return 8'b0110_0000;
            default: return 8'b1011_1000;
        endcase
    endfunction
endpackage

// File: rtl/sc_sel_lfsr.sv
// Select generator: a shift register extended with the all-zero state, so that
// it walks through all 2**W values once per period. It reloads SEED on restart
// and steps only when advance is high.
module sc_sel_lfsr #(
    parameter int unsigned W    = 4,
    parameter logic [W-1:0] SEED = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    input  logic         advance,
    output logic [W-1:0] sel
);
    localparam logic [W-1:0] TAPS = W'(sc_sp_pkg::lfsr_taps(W));

    logic fb;

    // Feedback bit, with the zero-state insertion term
    always_comb begin
        fb = (^(sel & TAPS)) ^ (sel[W-2:0] == '0);
    end

    // Select state register
    always_ff @(posedge clk) begin
        if (!rst_n)       sel <= SEED;
        else if (restart) sel <= SEED;
        else if (advance) sel <= {sel[W-2:0], fb};
    end
endmodule

// File: rtl/sc_bit_counter.sv
// Stream-to-binary counter: counts one-bits while enabled. Clear has priority.
// Assumes the run length never exceeds 2**W - 1, so the count does not wrap.
module sc_bit_counter #(
    parameter int unsigned W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic         bit_in,
    output logic [W-1:0] count
);
    // Count register
    always_ff @(posedge clk) begin
        if (!rst_n)            count <= '0;
        else if (clr)          count <= '0;
        else if (en && bit_in) count <= count + W'(1);
    end
endmodule

// File: rtl/sc_stream_mux.sv
// Random-select averaging multiplexer: forwards the stream picked by sel.
// Assumes N equals 2**SW, so every select value addresses a real input.
module sc_stream_mux #(
    parameter int unsigned N  = 16,
    parameter int unsigned SW = 4
) (
    input  logic [N-1:0]  streams,
    input  logic [SW-1:0] sel,
    output logic          bit_out
);
    // Pick one stream
    always_comb begin
        bit_out = streams[sel];
    end
endmodule

// File: rtl/sc_run_ctrl.sv
// Run controller: loads the run length on start, keeps busy high for that
// many cycles and then raises done until the next start. A length of zero
// gives done at once.
module sc_run_ctrl #(
    parameter int unsigned W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] len,
    output logic         busy,
    output logic         done
);
    logic [W-1:0] left;

    // Remaining-cycle counter and status flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left <= '0;
            busy <= 1'b0;
            done <= 1'b0;
        end else if (start) begin
            left <= len;
            busy <= (len != '0);
            done <= (len == '0);
        end else if (busy) begin
            left <= left - W'(1);
            if (left == W'(1)) begin
                busy <= 1'b0;
                done <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/sc_superpixel_bank.sv
// Top: sixteen per-pixel counters plus one super-pixel counter fed through a
// random-select multiplexer. All counters clear together on start and count
// while the run is busy. Assumes NPIX is a power of two.
module sc_superpixel_bank #(
    parameter int unsigned NPIX  = sc_sp_pkg::DEF_NPIX,
    parameter int unsigned CNT_W = sc_sp_pkg::DEF_CNT_W,
    localparam int unsigned SEL_W = $clog2(NPIX)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic [CNT_W-1:0]        len_i,
    input  logic [NPIX-1:0]         pix_i,
    output logic [NPIX*CNT_W-1:0]   pix_cnt_o,
    output logic [CNT_W-1:0]        sp_cnt_o,
    output logic [SEL_W-1:0]        sel_o,
    output logic                    busy_o,
    output logic                    done_o
);
    logic sp_bit;

    sc_run_ctrl #(.W(CNT_W)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start_i),
        .len   (len_i),
        .busy  (busy_o),
        .done  (done_o)
    );

    sc_sel_lfsr #(.W(SEL_W), .SEED(SEL_W'(1))) u_sel (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (start_i),
        .advance (busy_o),
        .sel     (sel_o)
    );

    sc_stream_mux #(.N(NPIX), .SW(SEL_W)) u_mux (
        .streams (pix_i),
        .sel     (sel_o),
        .bit_out (sp_bit)
    );

    for (genvar gi = 0; gi < NPIX; gi++) begin : g_pix
        sc_bit_counter #(.W(CNT_W)) u_cnt (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr    (start_i),
            .en     (busy_o),
            .bit_in (pix_i[gi]),
            .count  (pix_cnt_o[gi*CNT_W +: CNT_W])
        );
    end

    sc_bit_counter #(.W(CNT_W)) u_sp_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (start_i),
        .en     (busy_o),
        .bit_in (sp_bit),
        .count  (sp_cnt_o)
    );
endmodule

// File: rtl/sc_sp_checker.sv
// Checker: port-level properties of the super-pixel counter bank, bound to the top.
module sc_sp_checker #(
    parameter int unsigned NPIX  = 16,
    parameter int unsigned CNT_W = 9,
    parameter int unsigned SEL_W = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  start_i,
    input logic [CNT_W-1:0]      len_i,
    input logic [NPIX-1:0]       pix_i,
    input logic [NPIX*CNT_W-1:0] pix_cnt_o,
    input logic [CNT_W-1:0]      sp_cnt_o,
    input logic [SEL_W-1:0]      sel_o,
    input logic                  busy_o,
    input logic                  done_o
);
    for (genvar gi = 0; gi < NPIX; gi++) begin : g_chk
        a_r3_pix_step: assert property (@(posedge clk) disable iff (!rst_n)
            (busy_o && !start_i) |=> pix_cnt_o[gi*CNT_W +: CNT_W] ==
                $past(pix_cnt_o[gi*CNT_W +: CNT_W]) + CNT_W'($past(pix_i[gi])));
    end

    a_r4_sp_step: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !start_i) |=> sp_cnt_o == $past(sp_cnt_o) + CNT_W'($past(pix_i[sel_o])));

    a_r2_clear: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (sp_cnt_o == '0) && (pix_cnt_o == '0) && (busy_o != done_o));

    a_r6_flags_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && done_o));

    a_r7_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && len_i == '0) |=> (done_o && !busy_o));

    a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> ($stable(sp_cnt_o) && $stable(pix_cnt_o) && $stable(sel_o)));
endmodule

bind sc_superpixel_bank sc_sp_checker #(.NPIX(NPIX), .CNT_W(CNT_W), .SEL_W(SEL_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .len_i     (len_i),
    .pix_i     (pix_i),
    .pix_cnt_o (pix_cnt_o),
    .sp_cnt_o  (sp_cnt_o),
    .sel_o     (sel_o),
    .busy_o    (busy_o),
    .done_o    (done_o)
);

// File: tb/sc_superpixel_bank_tb.sv
// Bench: table-driven runs, then directed reset, idle, zero-length and restart tests.
module sc_superpixel_bank_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NPIX = 16;
    localparam int CW   = 9;
    localparam int SW   = 4;
    // Vector: {len[8:0], mode[1:0], arg[15:0]}; mode 0 constant mask, 1 random, 2 all ones
    localparam logic [26:0] VEC [6] = '{
        {9'd16,  2'd0, 16'hA5A5},
        {9'd256, 2'd2, 16'h0000},
        {9'd100, 2'd1, 16'h1D3B},
        {9'd256, 2'd1, 16'h7A51},
        {9'd1,   2'd0, 16'hFFFF},
        {9'd48,  2'd0, 16'h0001}
    };

    logic clk = 0, rst_n = 0, start_i = 0;
    logic [CW-1:0] len_i = '0;
    logic [NPIX-1:0] pix_i = '0;
    logic [NPIX*CW-1:0] pix_cnt_o;
    logic [CW-1:0] sp_cnt_o;
    logic [SW-1:0] sel_o;
    logic busy_o, done_o;

    int checks = 0, fails = 0, cyc = 0, exp_sp = 0;
    int exp_pix [NPIX];
    logic [15:0] seen, prng = 16'hACE1;
    bit finished = 0;

    sc_superpixel_bank u_dut (.clk(clk), .rst_n(rst_n), .start_i(start_i), .len_i(len_i),
        .pix_i(pix_i), .pix_cnt_o(pix_cnt_o), .sp_cnt_o(sp_cnt_o), .sel_o(sel_o),
        .busy_o(busy_o), .done_o(done_o));

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int pcnt(input int i);
        return int'(pix_cnt_o[i*CW +: CW]);
    endfunction

    // Pixel pattern for one cycle
    task automatic gen_pix(input logic [1:0] mode, input logic [15:0] arg);
        if (mode == 2'd0) pix_i = arg;
        else if (mode == 2'd2) pix_i = '1;
        else begin
            for (int i = 0; i < NPIX; i++) begin
                prng = prng ^ (prng << 7);
                prng = prng ^ (prng >> 9);
                prng = prng ^ (prng << 8);
                pix_i[i] = (prng[7:0] < 8'((i + 1) * 15));
            end
        end
    endtask

    // Start a run at a negedge; return at the negedge after the start edge
    task automatic start_run(input int len, input logic [15:0] seed);
        start_i = 1; len_i = CW'(len); prng = seed;
        @(posedge clk); @(negedge clk);
        start_i = 0;
        for (int i = 0; i < NPIX; i++) exp_pix[i] = 0;
        exp_sp = 0; cyc = 0; seen = '0;
    endtask

    // One counting cycle: drive, model, advance
    task automatic step(input logic [1:0] mode, input logic [15:0] arg, inout bit busy_ok);
        gen_pix(mode, arg);
        if (cyc == 0) chk(sel_o == 4'd1, "R5 first select", int'(sel_o), 1);
        if (!busy_o) busy_ok = 0;
        for (int i = 0; i < NPIX; i++) exp_pix[i] += int'(pix_i[i]);
        exp_sp += int'(pix_i[sel_o]);
        seen[sel_o] = 1'b1;
        if (cyc % 16 == 15) begin
            chk(seen == 16'hFFFF, "R5 select coverage", int'(seen), 16'hFFFF);
            seen = '0;
        end
        cyc++;
        @(posedge clk); @(negedge clk);
    endtask

    task automatic check_counts(input string tag);
        bit ok = 1;
        int bad = 0;
        for (int i = 0; i < NPIX; i++) if (pcnt(i) != exp_pix[i]) begin ok = 0; bad = i; end
        chk(ok, {"R3 pixel counts ", tag}, pcnt(bad), exp_pix[bad]);
        chk(int'(sp_cnt_o) == exp_sp, {"R4 super count ", tag}, int'(sp_cnt_o), exp_sp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        bit busy_ok;
        int sum;
        int sp_stable, sel_stable;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(sp_cnt_o == '0 && pix_cnt_o == '0, "R1 counts zero", int'(sp_cnt_o), 0);
        chk(!busy_o && !done_o, "R1 flags low", int'({busy_o, done_o}), 0);
        chk(sel_o == 4'd1, "R1 select seed", int'(sel_o), 1);

        // Table-driven runs
        for (int v = 0; v < 6; v++) begin
            int len = int'(VEC[v][26:18]);
            logic [1:0] mode = VEC[v][17:16];
            logic [15:0] arg = VEC[v][15:0];
            start_run(len, arg);
            chk(busy_o && !done_o, "R2 run starts busy", int'({busy_o, done_o}), 2);
            chk(sp_cnt_o == '0 && pix_cnt_o == '0, "R2 counts cleared", int'(sp_cnt_o), 0);
            busy_ok = 1;
            for (int t = 0; t < len; t++) step(mode, arg, busy_ok);
            chk(busy_ok, "R6 busy for whole run", 0, 1);
            chk(!busy_o && done_o, "R6 done after length", int'({busy_o, done_o}), 1);
            check_counts($sformatf("vec%0d", v));
            sum = 0;
            for (int i = 0; i < NPIX; i++) sum += exp_pix[i];
            if (mode != 2'd1 && len % 16 == 0)
                chk(16 * int'(sp_cnt_o) == sum, "R10 exact mean", 16 * int'(sp_cnt_o), sum);
            else if (mode == 2'd1) begin
                int diff = 16 * int'(sp_cnt_o) - sum;
                if (diff < 0) diff = -diff;
                chk(diff <= 16 * (len / 8 + 6), "R10 mean tolerance", diff, 16 * (len / 8 + 6));
            end
            if (mode == 2'd2)
                chk(pcnt(0) == 256 && pcnt(15) == 256 && sp_cnt_o == 9'd256,
                    "R11 full count no wrap", int'(sp_cnt_o), 256);
            // R9 idle inputs ignored
            sp_stable = int'(sp_cnt_o); sel_stable = int'(sel_o);
            pix_i = ~pix_i;
            repeat (3) @(negedge clk);
            pix_i = '1;
            @(negedge clk);
            check_counts("R9 idle hold");
            chk(int'(sp_cnt_o) == sp_stable && int'(sel_o) == sel_stable && done_o,
                "R9 idle select and done held", int'(sel_o), sel_stable);
        end

        // R7 zero length
        start_run(0, 16'h0);
        chk(done_o && !busy_o, "R7 zero length done", int'({busy_o, done_o}), 1);
        chk(sp_cnt_o == '0 && pix_cnt_o == '0, "R7 counts zero", int'(sp_cnt_o), 0);

        // R8 restart mid-run
        start_run(50, 16'h0);
        busy_ok = 1;
        for (int t = 0; t < 10; t++) step(2'd0, 16'hFFFF, busy_ok);
        start_run(20, 16'h0);
        chk(sp_cnt_o == '0 && pix_cnt_o == '0 && sel_o == 4'd1, "R8 restart cleared",
            int'(sp_cnt_o), 0);
        busy_ok = 1;
        for (int t = 0; t < 20; t++) step(2'd0, 16'h000F, busy_ok);
        chk(busy_ok && done_o && !busy_o, "R8 restart length", int'({busy_o, done_o}), 1);
        check_counts("R8 restart");
        chk(int'(sp_cnt_o) == 6, "R8 restart super value", int'(sp_cnt_o), 6);

        // R1 reset during run
        start_run(30, 16'h0);
        step(2'd2, 16'h0, busy_ok);
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        chk(sp_cnt_o == '0 && !busy_o && !done_o && sel_o == 4'd1, "R1 reset mid-run",
            int'(sp_cnt_o), 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule